// File: doc/BRIEF.md
# Verified Multi-Port Register File

This block is a register array with several independent read ports and several write ports. Reads are registered: an address presented with its read enable returns data on that port in the next cycle. When write enables on more than one port are raised together, a fixed priority picks one of them. A read of an entry that is being written in the same cycle returns the new value.

On top of the storage sits an integrity check for a configurable window of addresses, such as a handful of control and status entries. When a port reads an entry inside the window, a second port reads the same entry again in the next cycle. The re-read value is compared with what the first port delivered. A difference sets a sticky error flag that stays high until it is cleared. The verifying port is chosen in one of two ways. In reserved mode the highest-numbered read port only verifies. In shared mode any read port that is idle that cycle takes the job. A protected read that cannot get a verifier raises an unverified pulse. A fault hook on the read path lets a bench corrupt one port's output, so that the check can be provoked.

Top module: `regfile_verify`

## Requirements
- R1: A read enabled on a port in cycle t shows the stored entry on that port's `rd_data` from the edge that ends cycle t. A port whose read is not enabled holds its last value.
- R2: When several bits of `wr_en` are high, only the lowest-numbered enabled write port commits. `wr_grant` is combinational and one-hot, with bit i high for the committing port i. It is all zero when no write is enabled.
- R3: A read of an address that is being written in the same cycle returns the write data that commits in that cycle.
- R4: Protection covers addresses a with `prot_lo` <= a <= `prot_hi`, both bounds included. Reads outside this window are never verified and never affect `vfy_err` or `unverified`.
- R5: When `flt_en` is high, `flt_xor` is XORed onto the `rd_data` of port `flt_port`. If a protected read on port p in cycle t delivers in cycle t+1 a value that differs from the entry re-read in cycle t+1, `vfy_err` is high after the edge that ends cycle t+1.
- R6: With `DEDICATED`=1, the last read port is reserved for verification. Its `rd_en` is ignored and its `rd_data` stays zero.
- R7: With `DEDICATED`=0, the lowest-numbered port that is neither reading nor stalled in cycle t verifies the lowest-numbered protected read of cycle t. In cycle t+1 that port's bit in `rd_stall` is high, and a read requested on it in that cycle is ignored (its data holds). In reserved mode, `rd_stall` marks the reserved port instead.
- R8: `unverified` is high for the single cycle after any cycle in which a protected read did not get a verifier. This covers the case where every port is busy or stalled, and every protected read beyond the first in the same cycle.
- R9: `vfy_err` stays high until a cycle with `clr` high and no new mismatch. It is low after that cycle's edge. A new mismatch takes precedence over `clr`.
- R10: While `rst_n` is low, `rd_data`, `rd_stall`, `vfy_err` and `unverified` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | NWR | per-port write enable |
| wr_addr | input | NWR x AW | per-port write address |
| wr_data | input | NWR x WIDTH | per-port write data |
| wr_grant | output | NWR | one-hot, the write port that commits |
| rd_en | input | NRD | per-port read enable |
| rd_addr | input | NRD x AW | per-port read address |
| rd_data | output | NRD x WIDTH | per-port registered read data |
| rd_stall | output | NRD | port busy re-reading this cycle |
| prot_lo | input | AW | lowest protected address |
| prot_hi | input | AW | highest protected address |
| clr | input | 1 | clears the sticky error |
| flt_en | input | 1 | enables fault injection on one read output |
| flt_port | input | PW | read port whose output is corrupted |
| flt_xor | input | WIDTH | bit mask XORed onto that output |
| vfy_err | output | 1 | sticky verification mismatch |
| unverified | output | 1 | a protected read went without a check |

## Verification
A normal read request and a verifier re-read can target the same port in the same cycle. In shared mode the bench asks for a read on the port that was just taken as verifier. It then checks that the port's data holds and that `rd_stall` named that port. It also fills every other port while that port is stalled, and expects a one-cycle `unverified` pulse from the shared-mode instance but none from the reserved-mode instance. A second pairing is a write and a read to the same address in one cycle, judged by the bypassed value. A further pairing is a corrupted output paired with its re-read, judged by `vfy_err` two edges after the read.

// File: rtl/regfile_verify.sv
module regfile_verify #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int NRD = 4,
  parameter int NWR = 4,
  parameter int DEDICATED = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(NRD)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][AW-1:0]     wr_addr,
  input  logic [NWR-1:0][WIDTH-1:0]  wr_data,
  output logic [NWR-1:0]             wr_grant,
  input  logic [NRD-1:0]             rd_en,
  input  logic [NRD-1:0][AW-1:0]     rd_addr,
  output logic [NRD-1:0][WIDTH-1:0]  rd_data,
  output logic [NRD-1:0]             rd_stall,
  input  logic [AW-1:0]              prot_lo,
  input  logic [AW-1:0]              prot_hi,
  input  logic                       clr,
  input  logic                       flt_en,
  input  logic [PW-1:0]              flt_port,
  input  logic [WIDTH-1:0]           flt_xor,
  output logic                       vfy_err,
  output logic                       unverified
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [NRD-1:0][WIDTH-1:0] rq;
  logic [AW-1:0] w_addr, vaddr_q;
  logic [WIDTH-1:0] w_data;
  logic w_act, vld_q, err_q, unv_q, got, mism;
  logic [PW-1:0] pport, vport, pport_q, vport_q;
  logic [NRD-1:0] eff, prot, free;

  always_comb begin
    wr_grant = '0;
    w_addr = '0;
    w_data = '0;
    for (int i = NWR-1; i >= 0; i--) begin
      if (wr_en[i]) begin
        wr_grant = '0;
        wr_grant[i] = 1'b1;
        w_addr = wr_addr[i];
        w_data = wr_data[i];
      end
    end
  end
  assign w_act = |wr_en;

  always_ff @(posedge clk) begin
    if (w_act) mem[w_addr] <= w_data;
  end

  assign rd_stall = vld_q ? (NRD'(1) << vport_q) : '0;

  always_comb begin
    eff = '0;
    prot = '0;
    free = '0;
    for (int i = 0; i < NRD; i++) begin
      eff[i]  = rd_en[i] && !rd_stall[i] && !(DEDICATED != 0 && i == NRD-1);
      prot[i] = eff[i] && rd_addr[i] >= prot_lo && rd_addr[i] <= prot_hi;
      free[i] = (DEDICATED != 0) ? (i == NRD-1) : (!eff[i] && !rd_stall[i]);
    end
    pport = '0;
    vport = '0;
    for (int i = NRD-1; i >= 0; i--) begin
      if (prot[i]) pport = PW'(i);
      if (free[i]) vport = PW'(i);
    end
  end
  assign got = |prot && |free;

  always_comb begin
    for (int i = 0; i < NRD; i++)
      rd_data[i] = rq[i] ^ ((flt_en && flt_port == PW'(i)) ? flt_xor : '0);
  end

  assign mism = vld_q && (rd_data[pport_q] != mem[vaddr_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq <= '0;
      vld_q <= 1'b0;
      vport_q <= '0;
      pport_q <= '0;
      vaddr_q <= '0;
      err_q <= 1'b0;
      unv_q <= 1'b0;
    end else begin
      for (int i = 0; i < NRD; i++)
        if (eff[i]) rq[i] <= (w_act && w_addr == rd_addr[i]) ? w_data : mem[rd_addr[i]];
      vld_q <= got;
      if (got) begin
        vport_q <= vport;
        pport_q <= pport;
        vaddr_q <= rd_addr[pport];
      end
      err_q <= mism | (err_q & ~clr);
      unv_q <= $countones(prot) > (got ? 1 : 0);
    end
  end

  assign vfy_err = err_q;
  assign unverified = unv_q;

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant) && ((|wr_en) == (|wr_grant)));
  p_grant_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |-> wr_grant[0]);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_err && !clr |=> vfy_err);
  p_stall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_stall));
  p_unver_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unverified) |-> $past(|rd_en));

endmodule

// File: tb/regfile_verify_bench.sv
module regfile_verify_bench;
  localparam int D = 16, W = 8, NR = 4, NW = 4, AW = 4, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0] wr_en = '0;
  logic [NW-1:0][AW-1:0] wr_addr = '0;
  logic [NW-1:0][W-1:0] wr_data = '0;
  logic [NR-1:0] rd_en = '0;
  logic [NR-1:0][AW-1:0] rd_addr = '0;
  logic [AW-1:0] prot_lo = 4'd15, prot_hi = 4'd0;
  logic clr = 1'b0, flt_en = 1'b0;
  logic [PW-1:0] flt_port = '0;
  logic [W-1:0] flt_xor = '0;
  logic [NW-1:0] g_o, g_d;
  logic [NR-1:0][W-1:0] ro, rdd;
  logic [NR-1:0] st_o, st_d;
  logic err_o, err_d, unv_o, unv_d;
  logic [W-1:0] shadow [D];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  regfile_verify #(.DEPTH(D), .WIDTH(W), .NRD(NR), .NWR(NW), .DEDICATED(0)) u_regfile_verify (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_grant(g_o), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(ro), .rd_stall(st_o),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .clr(clr), .flt_en(flt_en), .flt_port(flt_port),
    .flt_xor(flt_xor), .vfy_err(err_o), .unverified(unv_o));

  regfile_verify #(.DEPTH(D), .WIDTH(W), .NRD(NR), .NWR(NW), .DEDICATED(1)) u_regfile_verify_ded (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_grant(g_d), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdd), .rd_stall(st_d),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .clr(clr), .flt_en(flt_en), .flt_port(flt_port),
    .flt_xor(flt_xor), .vfy_err(err_d), .unverified(unv_d));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done();
  end

  initial begin
    logic [W-1:0] saved;
    tick(); tick();
    check("R10 rd_data shared", ro, 0);
    check("R10 rd_data reserved", rdd, 0);
    check("R10 flags", {err_o, unv_o, err_d, unv_d, st_o, st_d}, 0);
    rst_n = 1'b1;
    tick();

    for (int a = 0; a < D; a++) begin
      wr_en = NW'(1) << (a % NW);
      wr_addr[a % NW] = AW'(a);
      wr_data[a % NW] = W'(a * 7 + 3);
      shadow[a] = W'(a * 7 + 3);
      tick();
    end
    wr_en = '0;

    for (int a = 0; a < D; a++) begin
      rd_en = 4'b0111;
      rd_addr[0] = AW'(a);
      rd_addr[1] = AW'((a + 1) % D);
      rd_addr[2] = AW'((a + 5) % D);
      tick();
      check("R1 port0", ro[0], shadow[a]);
      check("R1 port1", ro[1], shadow[(a + 1) % D]);
      check("R1 port2", ro[2], shadow[(a + 5) % D]);
    end
    rd_en = 4'b1000;
    rd_addr[3] = 4'd4;
    tick();
    check("R6 shared mode port3 reads", ro[3], shadow[4]);
    check("R6 reserved port3 stays zero", rdd[3], 0);
    rd_en = '0;
    tick();
    check("R1 hold", ro[0], shadow[15]);

    for (int m = 1; m < 16; m++) begin
      int lp;
      wr_en = NW'(m);
      for (int p = 0; p < NW; p++) begin
        wr_addr[p] = 4'd5;
        wr_data[p] = W'(8'h40 + m * 4 + p);
      end
      lp = 0;
      while (((m >> lp) & 1) == 0) lp++;
      #1;
      check("R2 grant", g_o, NW'(1) << lp);
      shadow[5] = W'(8'h40 + m * 4 + lp);
      tick();
      wr_en = '0;
      rd_en = 4'b0001;
      rd_addr[0] = 4'd5;
      tick();
      check("R2 winner data", ro[0], shadow[5]);
      rd_en = '0;
    end
    #1;
    check("R2 no grant idle", g_o, 0);

    wr_en = 4'b0001; wr_addr[0] = 4'd3; wr_data[0] = 8'hA5;
    rd_en = 4'b0001; rd_addr[0] = 4'd3;
    shadow[3] = 8'hA5;
    tick();
    check("R3 bypass", ro[0], 8'hA5);
    wr_en = '0; rd_en = '0;

    prot_lo = 4'd0; prot_hi = 4'd3;
    rd_en = 4'b0001; rd_addr[0] = 4'd2;
    tick();
    check("R7 verifier port1", st_o, 4'b0010);
    check("R7 reserved verifier", st_d, 4'b1000);
    rd_en = '0;
    tick();
    check("R5 clean read no error", {err_o, err_d}, 0);

    flt_en = 1'b1; flt_port = 2'd0; flt_xor = 8'h01;
    rd_en = 4'b0001; rd_addr[0] = 4'd1;
    tick();
    rd_en = '0;
    tick();
    check("R5 mismatch shared", err_o, 1);
    check("R5 mismatch reserved", err_d, 1);
    flt_en = 1'b0;
    tick(); tick();
    check("R9 sticky", {err_o, err_d}, 2'b11);
    clr = 1'b1;
    tick();
    clr = 1'b0;
    check("R9 cleared", {err_o, err_d}, 0);

    flt_en = 1'b1;
    rd_en = 4'b0001; rd_addr[0] = 4'd9;
    tick();
    check("R4 outside no stall", st_o, 0);
    rd_addr[0] = 4'd4;
    tick();
    rd_en = '0;
    tick();
    check("R4 outside window ignored", {err_o, err_d}, 0);
    rd_en = 4'b0001; rd_addr[0] = 4'd3;
    tick();
    rd_en = '0;
    tick();
    check("R4 upper bound inclusive", {err_o, err_d}, 2'b11);
    flt_en = 1'b0;
    clr = 1'b1;
    tick();
    clr = 1'b0;

    saved = ro[1];
    rd_en = 4'b0001; rd_addr[0] = 4'd0;
    tick();
    check("R7 stall port1", st_o, 4'b0010);
    rd_en = 4'b0010; rd_addr[1] = 4'd10;
    tick();
    check("R7 stalled read ignored", ro[1], saved);
    check("R7 stall released", st_o, 0);
    rd_en = 4'b0011; rd_addr[0] = 4'd1; rd_addr[1] = 4'd12;
    tick();
    check("R7 next free port2", st_o, 4'b0100);
    rd_en = '0;
    tick();

    rd_en = 4'b1111;
    for (int p = 0; p < NR; p++) rd_addr[p] = 4'd2;
    tick();
    check("R8 all busy shared", unv_o, 1);
    check("R8 extra protected reserved", unv_d, 1);
    rd_en = '0;
    tick();
    check("R8 pulse ends", {unv_o, unv_d}, 0);

    rd_en = 4'b0111; rd_addr[0] = 4'd2; rd_addr[1] = 4'd8; rd_addr[2] = 4'd9;
    tick();
    check("R8 verified shared", unv_o, 0);
    check("R7 verifier port3", st_o, 4'b1000);
    tick();
    check("R8 stalled port leaves none free", unv_o, 1);
    check("R8 reserved still verifies", unv_d, 0);
    rd_en = '0;
    tick();

    rd_en = 4'b0111; rd_addr[0] = 4'd0; rd_addr[1] = 4'd1; rd_addr[2] = 4'd9;
    tick();
    check("R8 second protected read", {unv_o, unv_d}, 2'b11);
    rd_en = '0;
    tick();
    check("R5 no error after checks", {err_o, err_d}, 0);

    done();
  end
endmodule